// File: doc/BRIEF.md
# Auto-Increment Host Address Sequencer

This block is the host-facing access front end of a peripheral. A microcontroller talks to it over a simple synchronous strobe bus. An address-phase select input decides whether a write carries an address or data. An address write loads a 16-bit pointer and moves no data. Each data read or data write after that uses the current pointer, and the pointer then steps by one. The host can therefore stream through consecutive locations without sending a new address each time.

The block decodes the pointer into one of three kinds of space, using its upper four bits:

- a control-register space, addressed by a unit number and an offset within that unit;
- a group of data-buffer spaces, each with a 12-bit word address;
- a hole, where reads return zero and writes are dropped.

Read and write strobes go to the selected target. Read data comes back registered, one clock after the strobe. Any data access at location zero also produces a pulse. A neighbouring interrupt block uses this pulse to clear its latched flags.

Top module: `host_addr_seq`

## Requirements
- R1: When `host_addr_phase`=1 and `host_wr`=1, `host_wdata` is loaded into the pointer on the clock edge. That cycle raises no target strobe and no `intr_clear`.
- R2: A data access is a cycle with `host_addr_phase`=0 and `host_rd` or `host_wr` at 1. The first data access after a load uses the loaded address. Each following data access uses the previous address plus one.
- R3: Bits 15..12 of the pointer select the space. When they are 0, a data read raises `reg_rd` and a data write raises `reg_wr`. In that case `reg_unit` equals pointer bits 11..8 and `reg_offset` equals bits 7..0.
- R4: When pointer bits 15..12 are 1, 2, 3 or 8 to 15, a data read raises `buf_rd` and a data write raises `buf_wr`. In that case `buf_id` equals bits 15..12 and `buf_word` equals bits 11..0.
- R5: When pointer bits 15..12 are 4 to 7, no target strobe is raised and a read returns 0. The pointer still advances by one.
- R6: `intr_clear` is high exactly in the cycle of a data access made while the pointer is 0x0000.
- R7: The pointer wraps from 0xFFFF to 0x0000. The access that follows the wrap raises `intr_clear`.
- R8: One cycle after a data read, `host_rvalid` is 1 and `host_rdata` holds the value `tgt_rdata` had during the strobe cycle (0 in the hole). Reads issued in consecutive cycles each return their own data.
- R9: After reset the pointer is 0x0000, `host_rvalid` is 0 and `host_rdata` is 0.
- R10: A data cycle with both `host_rd` and `host_wr` high acts as a write only. No read strobe is raised and no `host_rvalid` follows.
- R11: An address-phase cycle with only `host_rd` high has no effect. It raises no strobe and no `host_rvalid`, and it leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_phase | input | 1 | 1: the cycle carries an address, 0: the cycle carries data |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| host_wdata | input | 16 | Host write data or address |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| tgt_wdata | output | 16 | Write data to the targets |
| tgt_rdata | input | 16 | Read data from the selected target |
| reg_unit | output | 4 | Register unit number |
| reg_offset | output | 8 | Register offset within the unit |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| buf_id | output | 4 | Selected buffer number |
| buf_word | output | 12 | Buffer word address |
| buf_rd | output | 1 | Buffer read strobe |
| buf_wr | output | 1 | Buffer write strobe |
| intr_clear | output | 1 | Pulse on a data access at address 0x0000 |

## Verification
During back-to-back reads, two things happen in the same cycle: the registered data of one read is returned while the strobe of the next read is being issued. The bench runs read bursts with no idle cycles. In each cycle it checks the returned value against the address of the previous read, and the live strobe and decode against the next address. A second overlap is tested at the wrap: the read at 0xFFFF is followed directly by the read at 0x0000. The return of the first read and the `intr_clear` pulse with `reg_rd` of the second must then fall in the same cycle.

// File: rtl/host_addr_seq.sv
module host_addr_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_addr_phase,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic [DW-1:0] tgt_wdata,
  input  logic [DW-1:0] tgt_rdata,
  output logic [3:0]    reg_unit,
  output logic [7:0]    reg_offset,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [3:0]    buf_id,
  output logic [11:0]   buf_word,
  output logic          buf_rd,
  output logic          buf_wr,
  output logic          intr_clear
);
  localparam logic [AW-1:0] ZERO = '0;

  logic [AW-1:0] addr_q;
  logic [3:0]    nib;
  logic          data_rd, data_wr, access, in_reg, in_buf;

  assign nib     = addr_q[AW-1 -: 4];
  assign data_rd = !host_addr_phase && host_rd && !host_wr;
  assign data_wr = !host_addr_phase && host_wr;
  assign access  = data_rd || data_wr;
  assign in_reg  = (nib == 4'h0);
  assign in_buf  = nib[3] || (nib >= 4'h1 && nib <= 4'h3);

  assign reg_rd     = data_rd && in_reg;
  assign reg_wr     = data_wr && in_reg;
  assign buf_rd     = data_rd && in_buf;
  assign buf_wr     = data_wr && in_buf;
  assign intr_clear = access && (addr_q == ZERO);

  assign reg_unit   = addr_q[11:8];
  assign reg_offset = addr_q[7:0];
  assign buf_id     = nib;
  assign buf_word   = addr_q[11:0];
  assign tgt_wdata  = host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr_q <= ZERO;
    else if (host_addr_phase && host_wr)
      addr_q <= host_wdata[AW-1:0];
    else if (access)
      addr_q <= addr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= data_rd;
      if (data_rd)
        host_rdata <= (in_reg || in_buf) ? tgt_rdata : '0;
    end
  end
endmodule

// File: rtl/host_addr_seq_chk.sv
module host_addr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_addr_phase,
  input logic        host_rd,
  input logic        host_wr,
  input logic [15:0] host_wdata,
  input logic [15:0] addr_q,
  input logic        host_rvalid,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic        buf_rd,
  input logic        buf_wr,
  input logic        intr_clear
);
  logic acc;
  assign acc = !host_addr_phase && (host_rd || host_wr);

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr_phase && host_wr |=> addr_q == $past(host_wdata));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> addr_q == $past(addr_q) + 16'd1);

  p_reg_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |-> addr_q[15:12] == 4'h0);

  p_buf_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd || buf_wr) |-> (addr_q[15:12] != 4'h0) && !(addr_q[15:12] >= 4'h4 && addr_q[15:12] <= 4'h7));

  p_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q[15:12] >= 4'h4 && addr_q[15:12] <= 4'h7) |-> !(reg_rd || reg_wr || buf_rd || buf_wr));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    intr_clear |-> acc && addr_q == 16'h0000);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr_q == 16'hFFFF |=> addr_q == 16'h0000);

  p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || buf_rd) |=> host_rvalid);

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd, reg_wr, buf_rd, buf_wr}));

  p_addr_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr_phase |-> !(reg_rd || reg_wr || buf_rd || buf_wr || intr_clear));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr_phase && !host_wr |=> $stable(addr_q));
endmodule

bind host_addr_seq host_addr_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .host_addr_phase(host_addr_phase),
  .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
  .addr_q(addr_q), .host_rvalid(host_rvalid),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .buf_rd(buf_rd), .buf_wr(buf_wr),
  .intr_clear(intr_clear)
);

// File: tb/test_host_addr_seq.sv
module test_host_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_addr_phase = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata, tgt_wdata, tgt_rdata;
  logic        host_rvalid, reg_rd, reg_wr, buf_rd, buf_wr, intr_clear;
  logic [3:0]  reg_unit, buf_id;
  logic [7:0]  reg_offset;
  logic [11:0] buf_word;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign tgt_rdata = reg_rd ? {4'hE, reg_unit, reg_offset} : {buf_id, buf_word};

  host_addr_seq i_host_addr_seq (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [15:0] a);
    if (a[15:12] == 4'h0) return {4'hE, a[11:0]};
    if (a[15:12] >= 4'h4 && a[15:12] <= 4'h7) return 16'h0;
    return a;
  endfunction

  task automatic chk_decode(input logic [15:0] a, input bit rd, input bit wr, input string tag);
    logic [3:0] n = a[15:12];
    bit isreg = (n == 0);
    bit isbuf = n[3] || (n >= 1 && n <= 3);
    logic [3:0] exp = {rd & isreg, wr & isreg, rd & isbuf, wr & isbuf};
    chk({reg_rd, reg_wr, buf_rd, buf_wr} == exp, tag, {reg_rd, reg_wr, buf_rd, buf_wr}, exp);
    chk(intr_clear == (a == 16'h0), {tag, " R6 clear"}, intr_clear, a == 16'h0);
    if (isreg) chk({reg_unit, reg_offset} == a[11:0], {tag, " R3 fields"}, {reg_unit, reg_offset}, a[11:0]);
    if (isbuf) chk({buf_id, buf_word} == a, {tag, " R4 fields"}, {buf_id, buf_word}, a);
  endtask

  task automatic load(input logic [15:0] a);
    @(negedge clk);
    host_addr_phase = 1; host_wr = 1; host_rd = 0; host_wdata = a;
    #1;
    chk({reg_rd, reg_wr, buf_rd, buf_wr, intr_clear} == 0, "R1 load quiet", {reg_rd, reg_wr, buf_rd, buf_wr, intr_clear}, 0);
    @(negedge clk);
    host_addr_phase = 0; host_wr = 0;
  endtask

  task automatic write_burst(input logic [15:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      host_wr = 1; host_rd = 0; host_wdata = 16'hA500 + 16'(i);
      #1;
      chk_decode(a + 16'(i), 0, 1, tag);
      chk(tgt_wdata == host_wdata, {tag, " R4 wdata"}, tgt_wdata, host_wdata);
    end
    @(negedge clk); host_wr = 0;
    #1 chk(host_rvalid == 0, {tag, " no rvalid"}, host_rvalid, 0);
  endtask

  task automatic read_burst(input logic [15:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      host_rd = 1; host_wr = 0;
      #1;
      chk_decode(a + 16'(i), 1, 0, tag);
      if (i > 0) begin
        chk(host_rvalid == 1, {tag, " R8 rvalid"}, host_rvalid, 1);
        chk(host_rdata == exp_rd(a + 16'(i - 1)), {tag, " R8 data"}, host_rdata, exp_rd(a + 16'(i - 1)));
      end
    end
    @(negedge clk); host_rd = 0;
    #1;
    chk(host_rvalid == 1, {tag, " R8 rvalid last"}, host_rvalid, 1);
    chk(host_rdata == exp_rd(a + 16'(n - 1)), {tag, " R8 data last"}, host_rdata, exp_rd(a + 16'(n - 1)));
  endtask

  task automatic t_reset;
    #1;
    chk(host_rvalid == 0 && host_rdata == 0, "R9 reset outputs", {host_rvalid, host_rdata}, 0);
    read_burst(16'h0000, 1, "R9 pointer zero");
  endtask

  task automatic t_buffers;
    load(16'h2100); write_burst(16'h2100, 3, "R2 R4 buffer writes");
    load(16'h7FFE); write_burst(16'h7FFE, 3, "R5 R4 hole to buffer");
  endtask

  task automatic t_registers;
    load(16'h0305); read_burst(16'h0305, 4, "R3 R8 register reads");
  endtask

  task automatic t_hole;
    load(16'h4FFF); read_burst(16'h4FFF, 2, "R5 hole reads");
  endtask

  task automatic t_wrap;
    load(16'hFFFF); read_burst(16'hFFFF, 2, "R7 wrap");
    load(16'h0000); write_burst(16'h0000, 1, "R6 clear on write");
  endtask

  task automatic t_addr_rd;
    load(16'h1234);
    @(negedge clk); host_addr_phase = 1; host_rd = 1;
    #1 chk({reg_rd, reg_wr, buf_rd, buf_wr, intr_clear} == 0, "R11 quiet", {reg_rd, reg_wr, buf_rd, buf_wr, intr_clear}, 0);
    @(negedge clk); host_addr_phase = 0; host_rd = 0;
    #1 chk(host_rvalid == 0, "R11 no rvalid", host_rvalid, 0);
    read_burst(16'h1234, 1, "R11 pointer kept");
  endtask

  task automatic t_both;
    load(16'h3000);
    @(negedge clk); host_rd = 1; host_wr = 1; host_wdata = 16'h5555;
    #1 chk_decode(16'h3000, 0, 1, "R10 both");
    @(negedge clk); host_rd = 0; host_wr = 0;
    #1 chk(host_rvalid == 0, "R10 no rvalid", host_rvalid, 0);
    read_burst(16'h3001, 1, "R10 stepped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_buffers();
    t_registers();
    t_hole();
    t_wrap();
    t_addr_rd();
    t_both();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule